// File: doc/BRIEF.md
# Programmable Expandable Multifunction Gate

This block is a combinational logic gate whose function is chosen at run time. Eight data bits arrive as two groups of four (group 0 on bits 3:0, group 1 on bits 7:4). A three-bit function select picks one of eight functions: four single-level functions (AND, NAND, OR, NOR over all eight bits) and four two-level functions in which each group first reduces to one bit and the two group bits are then combined by a second operator (OR/AND, OR/NAND, AND/OR, AND/NOR).

A drive-enable control chooses between a driven output and a released, high-impedance one. The logical result and an enable flag are always available. A tri-state pin carries the result when driven and floats when released.

An expand input lets instances be chained into 16, 32 or more inputs. The output of a leading stage feeds the expand input of the next stage. With expand held low, the gate acts as a plain eight-input gate. No clock or state is involved, and every output follows its inputs within the same cycle.

Top module: `mfg_gate`

## Requirements
- R1: Function code 3'b000 (AND) gives y_o = 1 only when all eight data bits are 1 and expand_i is 0.
- R2: Function code 3'b100 (OR) gives y_o = 1 when any data bit is 1 or expand_i is 1, and 0 otherwise.
- R3: Codes 3'b001 (NAND) and 3'b101 (NOR) give the complement of codes 3'b000 and 3'b100 for the same inputs.
- R4: Code 3'b110 (OR/AND) gives y_o = 1 only when group 0 has a 1, group 1 has a 1, and expand_i is 0. Code 3'b111 (OR/NAND) gives its complement.
- R5: Code 3'b010 (AND/OR) gives y_o = 1 when group 0 is all ones, or group 1 is all ones, or expand_i is 1. Code 3'b011 (AND/NOR) gives its complement.
- R6: Function-code bit 0 means invert, bit 1 means two-level, and bit 2 means the first level is OR. When the second-level operator is OR, expand_i acts as one more OR term. When the second-level operator is AND, a high expand_i forces the AND term to 0. When expand_i is low it has no effect.
- R7: Chaining works as follows. A leading stage runs with expand_i = 0. Its function code is the final code with bit 0 replaced by 1 if the second level is AND (codes 000, 001, 110, 111) and by 0 otherwise. Its y_o drives the final stage's expand_i. The final y_o then equals the selected function over 16 bits, with four groups of four.
- R8: With drive_en = 1, y_oe_o is 1 and y_bus equals y_o. With drive_en = 0, y_oe_o is 0 and y_bus is released to high impedance. y_o is valid in both cases.
- R9: Unused inputs tied to the non-controlling level reduce the width of the gate. Tying them to 0 in OR mode leaves the OR of the remaining bits, and tying them to 1 in AND mode leaves the AND of the remaining bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 8 | Data bits; group 0 = [3:0], group 1 = [7:4] |
| fn_sel | input | 3 | Function code (bit0 invert, bit1 two-level, bit2 first level OR) |
| drive_en | input | 1 | 1 = drive the output pin, 0 = release it |
| expand_i | input | 1 | Cascade input from a leading stage; 0 when unused |
| y_o | output | 1 | Logical result |
| y_oe_o | output | 1 | Output-enable flag |
| y_bus | output | 1 | Tri-state copy of y_o |

## Verification
The expand input and the local data both feed the second-level operator in the same evaluation, so a cascade result depends on a leading stage and the final stage's own groups changing together. The bench provokes this in two ways. It sweeps every code with expand_i forced to 1 against all 256 data patterns. It also chains two instances and applies random and corner 16-bit patterns to both at once. Each vector is judged against a behavioural reference that counts ones per group, over two or four groups. Drive-enable toggles on the same vectors, so the enable flag and the pin are checked while the function result changes.

// File: rtl/mfg_pkg.sv
package mfg_pkg;

  localparam int unsigned N_GRP = 2;

  typedef enum logic [2:0] {
    FN_AND    = 3'b000,
    FN_NAND   = 3'b001,
    FN_ANDOR  = 3'b010,
    FN_ANDNOR = 3'b011,
    FN_OR     = 3'b100,
    FN_NOR    = 3'b101,
    FN_ORAND  = 3'b110,
    FN_ORNAND = 3'b111
  } fn_code_t;

  typedef struct packed {
    logic first_is_or;
    logic two_level;
    logic invert;
  } fn_cfg_t;

  function automatic fn_cfg_t decode_fn(input logic [2:0] code);
    fn_cfg_t c;
    c.first_is_or = code[2];
    c.two_level   = code[1];
    c.invert      = code[0];
    return c;
  endfunction

endpackage

// File: rtl/mfg_group_reduce.sv
module mfg_group_reduce #(
  parameter int unsigned GRP_W = 4
) (
  input  logic [GRP_W-1:0] data_i,
  output logic             all_o,
  output logic             any_o
);
  always_comb begin
    all_o = &data_i;
    any_o = |data_i;
  end
endmodule

// File: rtl/mfg_combine.sv
module mfg_combine
  import mfg_pkg::*;
#(
  parameter int unsigned NG = 2
) (
  input  fn_cfg_t       cfg,
  input  logic [NG-1:0] grp_and,
  input  logic [NG-1:0] grp_or,
  input  logic          expand_i,
  output logic          y_o
);
  logic [NG-1:0] first_lvl;
  logic          second_is_or;
  logic          core;

  always_comb begin
    first_lvl    = cfg.first_is_or ? grp_or : grp_and;
    // single-level: second operator equals first; two-level: the opposite one
    second_is_or = cfg.two_level ? ~cfg.first_is_or : cfg.first_is_or;
    if (second_is_or) core = (|first_lvl) | expand_i;
    else              core = (&first_lvl) & ~expand_i;
    y_o = core ^ cfg.invert;
  end
endmodule

// File: rtl/mfg_drive.sv
module mfg_drive (
  input  logic drive_en,
  input  logic y_i,
  output logic y_oe_o,
  output wire  y_bus
);
  always_comb y_oe_o = drive_en;
  assign y_bus = drive_en ? y_i : 1'bz;
endmodule

// File: rtl/mfg_gate.sv
module mfg_gate
  import mfg_pkg::*;
#(
  parameter int unsigned GRP_W = 4,
  localparam int unsigned DATA_W = N_GRP * GRP_W
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [2:0]        fn_sel,
  input  logic              drive_en,
  input  logic              expand_i,
  output logic              y_o,
  output logic              y_oe_o,
  output wire               y_bus
);
  logic [N_GRP-1:0] grp_and;
  logic [N_GRP-1:0] grp_or;
  fn_cfg_t          cfg;

  always_comb cfg = decode_fn(fn_sel);

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    mfg_group_reduce #(.GRP_W(GRP_W)) u_red (
      .data_i (data_i[g*GRP_W +: GRP_W]),
      .all_o  (grp_and[g]),
      .any_o  (grp_or[g])
    );
  end

  mfg_combine #(.NG(N_GRP)) u_comb (
    .cfg      (cfg),
    .grp_and  (grp_and),
    .grp_or   (grp_or),
    .expand_i (expand_i),
    .y_o      (y_o)
  );

  mfg_drive u_drv (
    .drive_en (drive_en),
    .y_i      (y_o),
    .y_oe_o   (y_oe_o),
    .y_bus    (y_bus)
  );

  always_comb begin
    if (fn_sel == FN_AND && !(&data_i))
      a_r1_and_needs_all: assert (!y_o) else $error("R1 AND high with a zero input");
    if (fn_sel == FN_OR && (|data_i))
      a_r2_or_any_high: assert (y_o) else $error("R2 OR low with a one input");
    if (fn_sel == FN_NOR && (|data_i))
      a_r3_nor_any_low: assert (!y_o) else $error("R3 NOR high with a one input");
    if (fn_sel == FN_ORAND && expand_i)
      a_r4_orand_expand: assert (!y_o) else $error("R4 OR/AND high with expand set");
    if (fn_sel == FN_ANDOR && expand_i)
      a_r5_andor_expand: assert (y_o) else $error("R5 AND/OR low with expand set");
    if (fn_sel == FN_AND && expand_i)
      a_r6_and_expand: assert (!y_o) else $error("R6 AND high with expand set");
    if (drive_en)
      a_r8_bus_follows: assert (y_bus === y_o) else $error("R8 pin differs from result");
  end
endmodule

// File: tb/mfg_gate_test.sv
module mfg_gate_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] data_f, data_l;
  logic [2:0] code, lead_code;
  logic       en, ext_drv, chain;
  logic       y, y_oe, lead_y, lead_oe, expand_in;
  wire        y_bus, lead_bus;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  assign expand_in = chain ? lead_y : ext_drv;

  mfg_gate uut (
    .data_i(data_f), .fn_sel(code), .drive_en(en), .expand_i(expand_in),
    .y_o(y), .y_oe_o(y_oe), .y_bus(y_bus)
  );

  mfg_gate u_lead (
    .data_i(data_l), .fn_sel(lead_code), .drive_en(1'b1), .expand_i(1'b0),
    .y_o(lead_y), .y_oe_o(lead_oe), .y_bus(lead_bus)
  );

  function automatic logic ref_eval(input logic [2:0] c, input logic [15:0] bits,
                                    input int ngroups, input logic ext);
    int  ones, hits, width;
    logic r;
    width = ngroups * 4;
    if (!c[1]) begin
      ones = 0;
      for (int i = 0; i < width; i++) ones += int'(bits[i]);
      if (c[2]) r = (ones > 0) || ext;
      else      r = (ones == width) && !ext;
    end else begin
      hits = 0;
      for (int g = 0; g < ngroups; g++) begin
        int cnt;
        cnt = 0;
        for (int k = 0; k < 4; k++) cnt += int'(bits[g*4+k]);
        if (c[2] ? (cnt > 0) : (cnt == 4)) hits++;
      end
      if (c[2]) r = (hits == ngroups) && !ext;
      else      r = (hits > 0) || ext;
    end
    return r ^ c[0];
  endfunction

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'b000:         return "R1";
      3'b100:         return "R2";
      3'b001, 3'b101: return "R3";
      3'b110, 3'b111: return "R4";
      default:        return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic got, input logic exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b (code %b data %h lead %h ext %0b)",
               tag, what, got, exp, code, data_f, data_l, expand_in);
    end
  endtask

  task automatic apply(input logic [2:0] c, input logic [7:0] f, input logic [7:0] l,
                       input logic e, input logic x, input logic ch, input string tag);
    logic exp_y;
    @(negedge clk);
    code      = c;
    lead_code = {c[2:1], (c[2:1] == 2'b00) || (c[2:1] == 2'b11)};
    data_f    = f;
    data_l    = l;
    en        = e;
    ext_drv   = x;
    chain     = ch;
    @(posedge clk);
    #2;
    exp_y = ch ? ref_eval(c, {l, f}, 4, 1'b0) : ref_eval(c, {8'h00, f}, 2, x);
    check(tag, "y_o", y, exp_y);
    check("R8", "y_oe_o", y_oe, e);
    if (e) check("R8", "y_bus", y_bus, exp_y);
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'h1234_5678;
    code = 3'b000; lead_code = 3'b001; data_f = 8'h00; data_l = 8'h00;
    en = 1'b0; ext_drv = 1'b0; chain = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // idle state: AND of zeros is 0, released pin flagged off (R1, R8)
    check("R1", "idle y_o", y, 1'b0);
    check("R8", "idle y_oe_o", y_oe, 1'b0);

    // stand-alone sweep: every code, every data pattern, expand low and high (R1..R6)
    for (int c = 0; c < 8; c++)
      for (int d = 0; d < 256; d++)
        for (int x = 0; x < 2; x++)
          apply(3'(c), 8'(d), 8'h00, 1'(d ^ x ^ c), 1'(x), 1'b0,
                (x == 1) ? "R6" : req_of(3'(c)));

    // unused inputs tied to the non-controlling level (R9)
    for (int s = 0; s < 64; s++) begin
      apply(3'b100, {2'b00, 6'(s)}, 8'h00, 1'b1, 1'b0, 1'b0, "R9");
      check("R9", "6-input OR", y, |6'(s));
      apply(3'b000, {2'b11, 6'(s)}, 8'h00, 1'b1, 1'b0, 1'b0, "R9");
      check("R9", "6-input AND", y, &6'(s));
    end

    // two chained stages as a 16-input gate (R7)
    for (int c = 0; c < 8; c++) begin
      apply(3'(c), 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, "R7");
      apply(3'(c), 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1, "R7");
      apply(3'(c), 8'h00, 8'hFF, 1'b0, 1'b0, 1'b1, "R7");
      apply(3'(c), 8'hFF, 8'h00, 1'b1, 1'b0, 1'b1, "R7");
      apply(3'(c), 8'hF0, 8'h0F, 1'b1, 1'b0, 1'b1, "R7");
      for (int n = 0; n < 600; n++) begin
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        apply(3'(c), seed[7:0], seed[15:8], seed[16], 1'b0, 1'b1, "R7");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule